// File: doc/BRIEF.md
# Circular Buffer Address Generator

This block forms the 5-bit addresses of a small data memory that keeps three rotating histories: raw input samples, second-derivative values and feature outputs. Each history sits in its own region of the memory, with its own slot count and its own head pointer. The head marks the slot that the next sample overwrites. An arithmetic datapath asks for "the value from d steps back in region r" and gets the address at once, with wrap-around kept inside that region.

A 3-bit select input names the region. A one-cycle increment pulse moves that region's head forward by one slot. A clear pulse returns every head to its first slot. The address output is a combinational function of the select, the delay and the current heads. An increment or clear therefore shows on the address one clock after the edge that samples it.

Top module: `circ_addr_gen`

## Requirements
- R1: After reset every head holds position 1. With delay 0, select 3'b011 gives address 0, select 3'b001 gives 5 and select 3'b010 gives 21.
- R2: Select 3'b011 picks the sample region (base 0, 5 slots). Select 3'b001 picks the derivative region (base 5, 16 slots). Select 3'b010 picks the feature region (base 21, 2 slots). Each base is the sum of the slot counts of the regions placed before it.
- R3: An increment pulse sampled at a clock edge advances the head of the selected region only, by one position. The new address is visible after that edge.
- R4: The sample head runs 1,2,3,4,5 and then returns to 1. It is never outside 1..5.
- R5: The address is base + (p - 1), where p = head - delay. With sample head 3 and delay 2, p is 1 and the address is 0.
- R6: When head - delay is below 1, p = head - delay + slot count. With sample head 1 and delay 1, p is 5 and the address is 4.
- R7: The derivative head wraps after 16 positions. With derivative head 2 and delay 5, p is 13 and the address is 17.
- R8: A clear pulse sets every head to 1 at the next edge. Clear wins over an increment in the same cycle.
- R9: Any select code other than 3'b011, 3'b001 or 3'b010 drives address 0, and an increment given with such a code moves no head.
- R10: The feature head alternates between 1 and 2. With feature head 1 and delay 1, the address is 22.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| incr_i | input | 1 | Advance the head of the selected region |
| clear_i | input | 1 | Return all heads to position 1 |
| region_sel_i | input | 3 | Region code |
| delay_i | input | 4 | Number of steps back from the head; must be below the region's slot count |
| addr_o | output | 5 | Memory address |

## Verification
The bench steps the sample head through its 5-to-1 wrap. A counter that ran to a power of two would instead produce address 5, which lies in the derivative region. Every delay is swept at a low head position, so an address generator that subtracts without adding the slot count back would point below the region's base. The bench runs the 16-slot derivative region through a full turn and gives increments to the other regions and to unused codes, so a shared head or a loose decode would show up as moved addresses. A clear together with an increment must land on position 1, not 2.

// File: rtl/circ_addr_pkg.sv
package circ_addr_pkg;

  localparam int NUM_REGIONS = 3;

  typedef enum logic [2:0] {
    SEL_DERIV  = 3'b001,
    SEL_FEAT   = 3'b010,
    SEL_SAMPLE = 3'b011
  } region_sel_e;

  // region index: 0 sample, 1 derivative, 2 feature; returns a one-hot hit vector
  function automatic logic [NUM_REGIONS-1:0] region_hit(input logic [2:0] code);
    logic [NUM_REGIONS-1:0] h;
    h = '0;
    case (code)
      SEL_SAMPLE: h[0] = 1'b1;
      SEL_DERIV:  h[1] = 1'b1;
      SEL_FEAT:   h[2] = 1'b1;
      default:    h = '0;
    endcase
    return h;
  endfunction

endpackage

// File: rtl/circ_rst_sync.sv
module circ_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic stage1_q;
  logic stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= 1'b0;
      stage2_q <= 1'b0;
    end else begin
      stage1_q <= 1'b1;
      stage2_q <= stage1_q;
    end
  end

  assign rst_n_sync = stage2_q;

endmodule

// File: rtl/circ_head_ctr.sv
module circ_head_ctr #(
  parameter int LEN    = 5,
  parameter int HEAD_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adv_i,
  input  logic              clr_i,
  output logic [HEAD_W-1:0] head_o
);

  localparam logic [HEAD_W-1:0] FIRST = HEAD_W'(1);
  localparam logic [HEAD_W-1:0] LAST  = HEAD_W'(LEN);

  logic [HEAD_W-1:0] head_q;
  logic [HEAD_W-1:0] head_d;
  logic              head_en;

  always_comb begin
    head_en = clr_i | adv_i;
    head_d  = head_q;
    if (clr_i) begin
      head_d = FIRST;
    end else if (adv_i) begin
      head_d = (head_q == LAST) ? FIRST : head_q + FIRST;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q <= FIRST;
    end else if (head_en) begin
      head_q <= head_d;
    end
  end

  assign head_o = head_q;

  // R4
  head_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (head_q >= FIRST) && (head_q <= LAST));

  // R3
  head_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_i && !clr_i && head_q != LAST) |=> (head_q == $past(head_q) + FIRST));

  // R4
  head_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_i && !clr_i && head_q == LAST) |=> (head_q == FIRST));

  // R8
  head_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (head_q == FIRST));

  // R9
  head_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv_i && !clr_i) |=> $stable(head_q));

endmodule

// File: rtl/circ_wrap_sub.sv
module circ_wrap_sub #(
  parameter int LEN    = 5,
  parameter int HEAD_W = 5,
  parameter int DLY_W  = 4
) (
  input  logic [HEAD_W-1:0] head_i,
  input  logic [DLY_W-1:0]  delay_i,
  output logic [HEAD_W-1:0] offset_o
);

  localparam int W = ((HEAD_W > DLY_W) ? HEAD_W : DLY_W) + 2;

  logic [W-1:0] head_w;
  logic [W-1:0] delay_w;
  logic [W-1:0] pos;

  always_comb begin
    head_w  = W'(head_i);
    delay_w = W'(delay_i);
    // positions run 1..LEN; fold back once when the step goes below 1
    if (head_w > delay_w) begin
      pos = head_w - delay_w;
    end else begin
      pos = head_w + W'(LEN) - delay_w;
    end
    offset_o = HEAD_W'(pos - W'(1));
  end

endmodule

// File: rtl/circ_addr_gen.sv
module circ_addr_gen #(
  parameter int SMP_LEN = 5,
  parameter int DRV_LEN = 16,
  parameter int FEA_LEN = 2,
  parameter int ADDR_W  = 5,
  parameter int DLY_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              incr_i,
  input  logic              clear_i,
  input  logic [2:0]        region_sel_i,
  input  logic [DLY_W-1:0]  delay_i,
  output logic [ADDR_W-1:0] addr_o
);
  import circ_addr_pkg::*;

  localparam int MAX_LEN = (SMP_LEN > DRV_LEN) ? ((SMP_LEN > FEA_LEN) ? SMP_LEN : FEA_LEN)
                                               : ((DRV_LEN > FEA_LEN) ? DRV_LEN : FEA_LEN);
  localparam int HEAD_W  = $clog2(MAX_LEN + 1);
  localparam int LENS  [NUM_REGIONS] = '{SMP_LEN, DRV_LEN, FEA_LEN};
  localparam int BASES [NUM_REGIONS] = '{0, SMP_LEN, SMP_LEN + DRV_LEN};

  logic                   rst_n_s;
  logic [NUM_REGIONS-1:0] hit;
  logic [HEAD_W-1:0]      head [NUM_REGIONS];
  logic [HEAD_W-1:0]      off  [NUM_REGIONS];
  logic [ADDR_W-1:0]      reg_addr [NUM_REGIONS];

  circ_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  assign hit = region_hit(region_sel_i);

  for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_region
    circ_head_ctr #(
      .LEN    (LENS[g]),
      .HEAD_W (HEAD_W)
    ) u_head (
      .clk    (clk),
      .rst_n  (rst_n_s),
      .adv_i  (incr_i & hit[g]),
      .clr_i  (clear_i),
      .head_o (head[g])
    );

    circ_wrap_sub #(
      .LEN    (LENS[g]),
      .HEAD_W (HEAD_W),
      .DLY_W  (DLY_W)
    ) u_sub (
      .head_i   (head[g]),
      .delay_i  (delay_i),
      .offset_o (off[g])
    );

    assign reg_addr[g] = ADDR_W'(BASES[g]) + ADDR_W'(off[g]);

    // R5 R6
    off_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
      (32'(delay_i) < LENS[g]) |-> (32'(off[g]) < LENS[g]));
  end

  always_comb begin
    addr_o = '0;
    for (int i = 0; i < NUM_REGIONS; i++) begin
      if (hit[i]) addr_o = addr_o | reg_addr[i];
    end
  end

  // R2
  sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    $onehot0(hit));

  // R9
  bad_sel_zero_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (hit == '0) |-> (addr_o == '0));

endmodule

// File: tb/circ_addr_gen_tb.sv
module circ_addr_gen_tb_top;

  logic       clk;
  logic       rst_n;
  logic       incr_i;
  logic       clear_i;
  logic [2:0] region_sel_i;
  logic [3:0] delay_i;
  logic [4:0] addr_o;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 0;

  // bench model: index 0 sample, 1 derivative, 2 feature
  int hd   [3];
  int lens [3] = '{5, 16, 2};
  int base [3] = '{0, 5, 21};
  logic [2:0] codes [3] = '{3'b011, 3'b001, 3'b010};

  circ_addr_gen dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .incr_i       (incr_i),
    .clear_i      (clear_i),
    .region_sel_i (region_sel_i),
    .delay_i      (delay_i),
    .addr_o       (addr_o)
  );

  initial clk = 0;
  always #5 clk = ~clk;

  function automatic int exp_addr(int r, int d);
    int p;
    p = hd[r] - d;
    if (p < 1) p += lens[r];
    return base[r] + p - 1;
  endfunction

  task automatic check(string req, int got, int exp);
    n_checks++;
    if (got != exp) begin
      n_fails++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic probe(string req, int r, int d);
    region_sel_i = codes[r];
    delay_i = 4'(d);
    #1;
    check(req, int'(addr_o), exp_addr(r, d));
  endtask

  task automatic pulse(logic [2:0] code, logic clr);
    @(negedge clk);
    region_sel_i = code;
    incr_i = 1'b1;
    clear_i = clr;
    @(negedge clk);
    incr_i = 1'b0;
    clear_i = 1'b0;
    if (clr) begin
      for (int r = 0; r < 3; r++) hd[r] = 1;
    end else begin
      for (int r = 0; r < 3; r++)
        if (codes[r] == code) hd[r] = (hd[r] == lens[r]) ? 1 : hd[r] + 1;
    end
  endtask

  task automatic t_reset();
    probe("R1 sample base", 0, 0);
    probe("R1 deriv base", 1, 0);
    probe("R1 feature base", 2, 0);
    region_sel_i = 3'b011; delay_i = 0; #1; check("R2 sample code", int'(addr_o), 0);
    region_sel_i = 3'b001; #1; check("R2 deriv code", int'(addr_o), 5);
    region_sel_i = 3'b010; #1; check("R2 feature code", int'(addr_o), 21);
  endtask

  task automatic t_sample_walk();
    for (int k = 0; k < 6; k++) begin
      pulse(3'b011, 1'b0);
      probe("R3 R4 sample head step", 0, 0);
      probe("R3 deriv untouched", 1, 0);
    end
  endtask

  task automatic t_delays();
    // bring sample head to 3
    while (hd[0] != 3) pulse(3'b011, 1'b0);
    region_sel_i = 3'b011; delay_i = 4'd2; #1;
    check("R5 head3 delay2", int'(addr_o), 0);
    for (int d = 0; d < 5; d++) probe("R5 R6 sample delay sweep", 0, d);
    while (hd[0] != 1) pulse(3'b011, 1'b0);
    region_sel_i = 3'b011; delay_i = 4'd1; #1;
    check("R6 head1 delay1", int'(addr_o), 4);
    for (int d = 0; d < 5; d++) probe("R6 wrap sweep", 0, d);
  endtask

  task automatic t_deriv();
    pulse(3'b001, 1'b0);
    region_sel_i = 3'b001; delay_i = 4'd5; #1;
    check("R7 head2 delay5", int'(addr_o), 17);
    for (int k = 0; k < 16; k++) begin
      pulse(3'b001, 1'b0);
      probe("R7 deriv walk", 1, 0);
      probe("R7 deriv delay15", 1, 15);
    end
    probe("R3 sample untouched by deriv", 0, 0);
  endtask

  task automatic t_feature();
    region_sel_i = 3'b010; delay_i = 4'd1; #1;
    check("R10 head1 delay1", int'(addr_o), 22);
    for (int k = 0; k < 3; k++) begin
      pulse(3'b010, 1'b0);
      probe("R10 feature d0", 2, 0);
      probe("R10 feature d1", 2, 1);
    end
  endtask

  task automatic t_bad_sel();
    logic [2:0] bad [5] = '{3'b000, 3'b100, 3'b101, 3'b110, 3'b111};
    for (int i = 0; i < 5; i++) begin
      region_sel_i = bad[i]; delay_i = 4'd0; #1;
      check("R9 unused code address", int'(addr_o), 0);
      pulse(bad[i], 1'b0);
    end
    for (int r = 0; r < 3; r++) probe("R9 heads unmoved", r, 0);
  endtask

  task automatic t_clear();
    pulse(3'b011, 1'b0);
    pulse(3'b001, 1'b0);
    pulse(3'b011, 1'b1);
    region_sel_i = 3'b011; delay_i = 0; #1; check("R8 sample cleared", int'(addr_o), 0);
    region_sel_i = 3'b001; #1; check("R8 deriv cleared", int'(addr_o), 5);
    region_sel_i = 3'b010; #1; check("R8 feature cleared", int'(addr_o), 21);
  endtask

  initial begin
    incr_i = 0; clear_i = 0; region_sel_i = 3'b011; delay_i = 0;
    rst_n = 1;
    #1 rst_n = 0;
    for (int r = 0; r < 3; r++) hd[r] = 1;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (5) @(negedge clk);
    t_reset();
    t_sample_walk();
    t_delays();
    t_deriv();
    t_feature();
    t_bad_sel();
    t_clear();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
    end
  end

endmodule